// File: doc/BRIEF.md
# Numbered Video Packet Framebuffer Writer

This block takes a byte stream of video packets and turns it into framebuffer writes. Each packet opens with a one-byte sequence number, and pixel payload bytes follow it. Byte pairs are joined into 16-bit RGB pixels. The target address comes from the sequence number and the pixel's position inside the packet, not from the order in which packets arrive. A packet that the link loses, and that is never sent again, therefore leaves only its own slot of the frame stale. Every other packet still lands in its correct place.

Address/data pairs go into a small write FIFO. The memory port can then take them whenever the display reader leaves it free. When the FIFO fills, the byte input stalls. When the last packet of a frame completes, the block raises a one-cycle pulse and disarms. It accepts nothing more until a packet numbered 1 opens the next frame. Packets with an out-of-range number and packets that end early set sticky error flags, which only reset clears.

Top module: `vpkt_fb_writer`

## Requirements
- R1: The first byte of a packet is its number. Payload bytes pair up as low byte then high byte into one 16-bit pixel: red in bits 15:11, green in bits 10:5, blue in bits 4:0. The pixel is written unchanged on `wr_data`.
- R2: The pixel at index k (counting from 0) of packet n is written to address FRAME_BASE + (n-1)*PIX_PER_PKT + k.
- R3: `in_ready` is low while the write FIFO holds FIFO_DEPTH entries. Every accepted pixel leaves on the write port once, in acceptance order. `wr_addr` and `wr_data` hold steady while `wr_valid` is high and `wr_ready` is low.
- R4: A packet numbered 0 or above PKTS_PER_FRAME produces no write and sets `num_err`, which stays high until reset.
- R5: A kept packet whose `in_last` arrives before 2*PIX_PER_PKT payload bytes sets `short_err`, which stays high until reset. Its completed pixels stay written, and a lone trailing low byte is dropped.
- R6: When the final payload byte of packet PKTS_PER_FRAME is accepted in an armed frame, `frame_done` is high for exactly the next cycle.
- R7: After reset and after each `frame_done`, the block is disarmed. Packets with an in-range number other than 1 are discarded without error until a packet numbered 1 arrives.
- R8: Payload bytes beyond 2*PIX_PER_PKT are discarded up to `in_last` and raise no error. The byte after `in_last` is read as the next packet number.
- R9: Packets may arrive in any order or with gaps. Each packet is placed only by its own number, and `frame_done` follows packet PKTS_PER_FRAME even if an earlier packet is missing.
- R10: After reset, `in_ready` is 1 and `wr_valid`, `frame_done`, `num_err` and `short_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a packet |
| in_ready | output | 1 | Block can take a byte |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | ADDR_W | Framebuffer pixel address |
| wr_data | output | 16 | RGB 5-6-5 pixel |
| wr_ready | input | 1 | Memory port takes the pending write |
| frame_done | output | 1 | One-cycle pulse when a frame's last packet completes |
| num_err | output | 1 | Sticky: bad packet number seen |
| short_err | output | 1 | Sticky: kept packet ended early |

## Verification
The bench builds the block with 3 pixels per packet, 4 packets per frame, a FIFO depth of 3 and a frame base of 16. With these values every packet length from an empty payload up to past the full payload can be swept. Whole frames can be sent in permuted order and with a gap. Every out-of-range packet number class is reached in a few hundred cycles. The FIFO depth is not a power of two, so the pointer wrap path is exercised. A randomly stalling write port keeps the FIFO full often enough that the input stall is seen repeatedly.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

   typedef struct packed {
      logic [4:0] red;
      logic [5:0] green;
      logic [4:0] blue;
   } rgb565_t;

   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,
      ST_PAY  = 2'd1,
      ST_DROP = 2'd2
   } parse_st_t;

   function automatic rgb565_t join_pixel(input logic [7:0] lo, input logic [7:0] hi);
      join_pixel = rgb565_t'({hi, lo});
   endfunction

endpackage

// File: rtl/vpw_fifo.sv
module vpw_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   output logic             full,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             not_empty,
   output logic [LVL_W-1:0] level
);

   generate
      if (DEPTH == 1) begin : g_single
         logic             held_q;
         logic [WIDTH-1:0] data_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q <= 1'b0;
               data_q <= '0;
            end else if (push && !held_q) begin
               held_q <= 1'b1;
               data_q <= push_data;
            end else if (pop && held_q) begin
               held_q <= 1'b0;
            end
         end

         assign full      = held_q;
         assign not_empty = held_q;
         assign pop_data  = data_q;
         assign level     = LVL_W'(held_q);
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

         logic [WIDTH-1:0] mem_q [DEPTH];
         logic [PTR_W-1:0] wp_q, rp_q;
         logic [LVL_W-1:0] cnt_q;
         logic             do_push, do_pop;

         assign full      = (cnt_q == LVL_W'(DEPTH));
         assign not_empty = (cnt_q != '0);
         assign do_push   = push && !full;
         assign do_pop    = pop && not_empty;
         assign pop_data  = mem_q[rp_q];
         assign level     = cnt_q;

         always_ff @(posedge clk) begin
            if (do_push) mem_q[wp_q] <= push_data;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) wp_q <= (wp_q == LAST_SLOT) ? '0 : wp_q + PTR_W'(1);
               if (do_pop)  rp_q <= (rp_q == LAST_SLOT) ? '0 : rp_q + PTR_W'(1);
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + LVL_W'(1);
                  2'b01:   cnt_q <= cnt_q - LVL_W'(1);
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vpw_addr_gen.sv
module vpw_addr_gen #(
   parameter int ADDR_W      = 16,
   parameter int PIX_PER_PKT = 511,
   parameter int FRAME_BASE  = 0
) (
   input  logic [7:0]        pkt_num,
   output logic [ADDR_W-1:0] pkt_base
);

   localparam logic [31:0] STRIDE = 32'(PIX_PER_PKT);
   localparam logic [31:0] BASE   = 32'(FRAME_BASE);

   logic [31:0] slot;
   logic [31:0] full_addr;

   always_comb begin
      slot      = (pkt_num == 8'd0) ? 32'd0 : (32'(pkt_num) - 32'd1);
      full_addr = BASE + slot * STRIDE;
   end

   assign pkt_base = full_addr[ADDR_W-1:0];

endmodule

// File: rtl/vpw_parser.sv
module vpw_parser
   import vpw_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int PIX_PER_PKT    = 511,
   parameter int PKTS_PER_FRAME = 38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_take,
   input  logic [7:0]        byte_data,
   input  logic              byte_last,
   input  logic [ADDR_W-1:0] pkt_base,
   output logic              px_push,
   output logic [ADDR_W-1:0] px_addr,
   output logic [15:0]       px_data,
   output logic              frame_done,
   output logic              num_err,
   output logic              short_err
);

   localparam int IDX_W = (PIX_PER_PKT > 1) ? $clog2(PIX_PER_PKT) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_PER_PKT - 1);
   localparam logic [7:0] TOP_NUM = 8'(PKTS_PER_FRAME);

   parse_st_t         st_q;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic              phase_q;
   logic [7:0]        lo_q;
   logic              closing_q;
   logic              armed_q;

   logic num_bad, num_first, hdr_keep, pkt_full;

   always_comb begin
      num_bad   = (byte_data == 8'd0) || (byte_data > TOP_NUM);
      num_first = (byte_data == 8'd1);
      hdr_keep  = !num_bad && (armed_q || num_first);
      px_push   = byte_take && (st_q == ST_PAY) && phase_q;
      pkt_full  = px_push && (idx_q == LAST_IDX);
      px_addr   = base_q + ADDR_W'(idx_q);
      px_data   = join_pixel(lo_q, byte_data);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_HDR;
         base_q     <= '0;
         idx_q      <= '0;
         phase_q    <= 1'b0;
         lo_q       <= '0;
         closing_q  <= 1'b0;
         armed_q    <= 1'b0;
         frame_done <= 1'b0;
         num_err    <= 1'b0;
         short_err  <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (byte_take) begin
            case (st_q)
               ST_HDR: begin
                  if (num_bad) num_err <= 1'b1;
                  if (!num_bad && num_first) armed_q <= 1'b1;
                  base_q    <= pkt_base;
                  idx_q     <= '0;
                  phase_q   <= 1'b0;
                  closing_q <= (byte_data == TOP_NUM);
                  if (byte_last) begin
                     st_q <= ST_HDR;
                     if (hdr_keep) short_err <= 1'b1;
                  end else begin
                     st_q <= hdr_keep ? ST_PAY : ST_DROP;
                  end
               end
               ST_PAY: begin
                  if (!phase_q) begin
                     lo_q    <= byte_data;
                     phase_q <= 1'b1;
                  end else begin
                     phase_q <= 1'b0;
                     idx_q   <= idx_q + IDX_W'(1);
                  end
                  if (pkt_full) begin
                     if (closing_q) begin
                        frame_done <= 1'b1;
                        armed_q    <= 1'b0;
                     end
                     st_q <= byte_last ? ST_HDR : ST_DROP;
                  end else if (byte_last) begin
                     short_err <= 1'b1;
                     st_q      <= ST_HDR;
                  end
               end
               ST_DROP: begin
                  if (byte_last) st_q <= ST_HDR;
               end
               default: st_q <= ST_HDR;
            endcase
         end
      end
   end

endmodule

// File: rtl/vpkt_fb_writer.sv
module vpkt_fb_writer #(
   parameter int ADDR_W         = 16,
   parameter int PIX_PER_PKT    = 511,
   parameter int PKTS_PER_FRAME = 38,
   parameter int FIFO_DEPTH     = 8,
   parameter int FRAME_BASE     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [15:0]       wr_data,
   input  logic              wr_ready,
   output logic              frame_done,
   output logic              num_err,
   output logic              short_err
);

   localparam int ENTRY_W = ADDR_W + 16;
   localparam int LVL_W   = $clog2(FIFO_DEPTH + 1);
   localparam longint SPAN = longint'(FRAME_BASE) + longint'(PKTS_PER_FRAME) * longint'(PIX_PER_PKT);

   generate
      if (PKTS_PER_FRAME < 1 || PKTS_PER_FRAME > 255) begin : g_bad_pkts
         $error("PKTS_PER_FRAME must lie in 1..255");
      end
      if (PIX_PER_PKT < 1) begin : g_bad_pix
         $error("PIX_PER_PKT must be at least 1");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 31 || SPAN > (longint'(1) <<< ADDR_W)) begin : g_bad_addr
         $error("ADDR_W cannot hold the frame");
      end
   endgenerate

   logic              take;
   logic [ADDR_W-1:0] pkt_base;
   logic              px_push;
   logic [ADDR_W-1:0] px_addr;
   logic [15:0]       px_data;
   logic              fifo_full;
   logic [ENTRY_W-1:0] head;
   logic [LVL_W-1:0]  fifo_level;

   assign in_ready = !fifo_full;
   assign take     = in_valid && in_ready;

   vpw_addr_gen #(
      .ADDR_W      (ADDR_W),
      .PIX_PER_PKT (PIX_PER_PKT),
      .FRAME_BASE  (FRAME_BASE)
   ) u_addr (
      .pkt_num  (in_data),
      .pkt_base (pkt_base)
   );

   vpw_parser #(
      .ADDR_W         (ADDR_W),
      .PIX_PER_PKT    (PIX_PER_PKT),
      .PKTS_PER_FRAME (PKTS_PER_FRAME)
   ) u_parse (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_take  (take),
      .byte_data  (in_data),
      .byte_last  (in_last),
      .pkt_base   (pkt_base),
      .px_push    (px_push),
      .px_addr    (px_addr),
      .px_data    (px_data),
      .frame_done (frame_done),
      .num_err    (num_err),
      .short_err  (short_err)
   );

   vpw_fifo #(
      .WIDTH (ENTRY_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (px_push),
      .push_data ({px_addr, px_data}),
      .full      (fifo_full),
      .pop       (wr_ready),
      .pop_data  (head),
      .not_empty (wr_valid),
      .level     (fifo_level)
   );

   assign wr_addr = head[ENTRY_W-1:16];
   assign wr_data = head[15:0];

endmodule

// File: rtl/vpw_checks.sv
module vpw_checks #(
   parameter int ADDR_W         = 16,
   parameter int PIX_PER_PKT    = 511,
   parameter int PKTS_PER_FRAME = 38,
   parameter int FIFO_DEPTH     = 8,
   parameter int FRAME_BASE     = 0,
   parameter int LVL_W          = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [15:0]       wr_data,
   input logic              wr_ready,
   input logic              frame_done,
   input logic              num_err,
   input logic              short_err,
   input logic [LVL_W-1:0]  fifo_level
);

   localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(FRAME_BASE);
   localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(FRAME_BASE + PKTS_PER_FRAME * PIX_PER_PKT - 1);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == LVL_W'(FIFO_DEPTH)) |-> !in_ready);

   assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr >= LO_ADDR && wr_addr <= HI_ADDR));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   assert_num_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      num_err |=> num_err);

   assert_num_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(num_err) |-> $past(in_valid && in_ready));

   assert_short_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      short_err |=> short_err);

endmodule

bind vpkt_fb_writer vpw_checks #(
   .ADDR_W         (ADDR_W),
   .PIX_PER_PKT    (PIX_PER_PKT),
   .PKTS_PER_FRAME (PKTS_PER_FRAME),
   .FIFO_DEPTH     (FIFO_DEPTH),
   .FRAME_BASE     (FRAME_BASE),
   .LVL_W          (LVL_W)
) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .wr_valid   (wr_valid),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .wr_ready   (wr_ready),
   .frame_done (frame_done),
   .num_err    (num_err),
   .short_err  (short_err),
   .fifo_level (fifo_level)
);

// File: tb/vpkt_fb_writer_test.sv
`timescale 1ns/1ps
module vpkt_fb_writer_test;

   localparam int PIX  = 3;
   localparam int PKTS = 4;
   localparam int DEP  = 3;
   localparam int AW   = 8;
   localparam int BASE = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_last = 1'b0;
   logic          in_ready;
   logic          wr_valid;
   logic [AW-1:0] wr_addr;
   logic [15:0]   wr_data;
   logic          wr_ready = 1'b1;
   logic          frame_done;
   logic          num_err;
   logic          short_err;

   always #2.5 clk = ~clk;

   vpkt_fb_writer #(
      .ADDR_W(AW), .PIX_PER_PKT(PIX), .PKTS_PER_FRAME(PKTS),
      .FIFO_DEPTH(DEP), .FRAME_BASE(BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .frame_done(frame_done), .num_err(num_err), .short_err(short_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [23:0] exp_q[$];
   bit   stall = 1'b0;
   bit   saw_bp = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   int   done_cnt = 0;
   int   exp_done = 0;
   bit   armed_m = 1'b0;
   bit   exp_num = 1'b0;
   bit   exp_short = 1'b0;

   task automatic chk(input string tag, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic logic [7:0] pay(input int num, input int i);
      return 8'((num * 37 + i * 11 + 5) & 255);
   endfunction

   // write-port sink: choose ready, then compare the entry taken at the next edge
   initial begin
      forever begin
         @(negedge clk);
         wr_ready = stall ? (lfsr[0] & lfsr[2]) : 1'b1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         if (rst_n) begin
            if (!in_ready) saw_bp = 1'b1;
            if (frame_done) done_cnt++;
            if (wr_valid && wr_ready) begin
               if (exp_q.size() == 0) begin
                  chk("R3 unexpected write", 1, 0);
               end else begin
                  logic [23:0] e;
                  e = exp_q.pop_front();
                  chk("R2 write address", int'(wr_addr), int'(e[23:16]));
                  chk("R1 pixel data", int'(wr_data), int'(e[15:0]));
               end
            end
         end
      end
   end

   task automatic send_byte(input logic [7:0] d, input logic last);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = last;
      while (!in_ready) @(negedge clk);
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // sends packet num with nbytes payload bytes and updates the model
   task automatic send_pkt(input int num, input int nbytes);
      bit bad, keep;
      bad  = (num == 0) || (num > PKTS);
      if (bad) exp_num = 1'b1;
      keep = !bad && (armed_m || num == 1);
      if (!bad && num == 1) armed_m = 1'b1;
      if (keep) begin
         for (int k = 0; k < PIX; k++) begin
            if (2 * k + 1 < nbytes)
               exp_q.push_back({8'(BASE + (num - 1) * PIX + k), pay(num, 2 * k + 1), pay(num, 2 * k)});
         end
         if (nbytes < 2 * PIX) exp_short = 1'b1;
         else if (num == PKTS) begin
            exp_done++;
            armed_m = 1'b0;
         end
      end
      send_byte(8'(num), nbytes == 0);
      for (int i = 0; i < nbytes; i++) send_byte(pay(num, i), i == nbytes - 1);
   endtask

   task automatic drain(input string tag);
      int t;
      go_idle();
      t = 0;
      while ((exp_q.size() != 0 || wr_valid) && t < 2000) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      chk({tag, " R3 all writes delivered"}, exp_q.size(), 0);
      chk({tag, " R6 frame_done count"}, done_cnt, exp_done);
      chk({tag, " R4 num_err"}, int'(num_err), int'(exp_num));
      chk({tag, " R5 short_err"}, int'(short_err), int'(exp_short));
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk("R10 in_ready", int'(in_ready), 1);
      chk("R10 wr_valid", int'(wr_valid), 0);
      chk("R10 frame_done", int'(frame_done), 0);
      chk("R10 num_err", int'(num_err), 0);
      chk("R10 short_err", int'(short_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: disarmed after reset, packets 2 and 4 discarded silently
      send_pkt(2, 2 * PIX);
      send_pkt(PKTS, 2 * PIX);
      drain("R7 pre-arm");

      // R1 R2 R6: whole frame in order, free-running sink
      for (int n = 1; n <= PKTS; n++) send_pkt(n, 2 * PIX);
      drain("R6 ordered frame");

      // R7: disarmed after frame_done
      send_pkt(3, 2 * PIX);
      send_pkt(PKTS, 2 * PIX);
      drain("R7 post-frame");

      // R9 R3: permuted frame with a stalling sink
      stall = 1'b1;
      send_pkt(1, 2 * PIX);
      send_pkt(3, 2 * PIX);
      send_pkt(2, 2 * PIX);
      send_pkt(PKTS, 2 * PIX);
      drain("R9 permuted frame");

      // R9: frame with packet 3 lost
      send_pkt(1, 2 * PIX);
      send_pkt(2, 2 * PIX);
      send_pkt(PKTS, 2 * PIX);
      drain("R9 gap frame");
      chk("R3 input stalled under back-pressure", int'(saw_bp), 1);
      stall = 1'b0;

      // R8: over-long packets, then a normal packet parses cleanly
      send_pkt(1, 2 * PIX + 3);
      send_pkt(2, 2 * PIX + 1);
      send_pkt(3, 2 * PIX);
      drain("R8 long packets");

      // R5: sweep every short length on a kept packet
      for (int len = 0; len < 2 * PIX; len++) begin
         send_pkt(2, len);
         drain("R5 short sweep");
      end
      send_pkt(PKTS, 2 * PIX);
      drain("R6 frame closes after short packets");

      // R4: bad numbers while armed, sticky afterwards
      send_pkt(1, 2 * PIX);
      send_pkt(0, 2 * PIX);
      send_pkt(PKTS + 1, 2 * PIX);
      send_pkt(255, 1);
      drain("R4 bad numbers");
      send_pkt(2, 2 * PIX);
      send_pkt(PKTS, 2 * PIX);
      drain("R4 sticky after good traffic");

      summary();
      $finish;
   end

endmodule